// File: doc/BRIEF.md
# Fuse-Programming Voltage Ramp Sequencer

This block walks a supply's voltage-target code to a safe programming level and back again, one step at a time. An enter request stores the incoming target code. The block then lowers that code by one per step until it reaches the floor of 2. An exit request raises the code from 2 back up to the stored value. Every code the block writes is held for a fixed dwell. At the end of either ramp it waits a longer settle period, then reports completion. The floor of 2 lies above the nominal minimum of 0, so the rail is not pulled too low under load.

All timing is counted in clock cycles. The parameter `CYC_PER_US` gives the number of cycles per microsecond. `STEP_US` sets the dwell (500 us by default) and `SETTLE_US` sets the final settle (10 ms by default). The analog regulator lies outside the block. It sees only the code output and its write strobe.

Top module: `vramp_seq`

## Requirements
- R1: After reset, `code_o` is 0 and `wr_o`, `busy_o` and `done_o` are low.
- R2: An idle enter request whose `cur_code_i` is above 2 stores that code. It then writes `cur_code_i-1`, `cur_code_i-2`, and so on down to 2, in that order. The first write is visible in the cycle right after the clock edge that samples the request.
- R3: An idle enter request with `cur_code_i` of 2 or less writes nothing. It still stores the code and goes straight to the settle period.
- R4: An idle exit request writes every code from 2 up to the stored code, in ascending order, both ends included.
- R5: Successive writes in one ramp are exactly STEP = `CYC_PER_US*STEP_US` cycles apart.
- R6: `done_o` is a single-cycle pulse. If a ramp made n writes, the pulse comes n*STEP + SETTLE cycles after the request edge, where SETTLE = `CYC_PER_US*SETTLE_US`.
- R7: `wr_o` is high for one cycle per write. `code_o` changes only in a cycle where `wr_o` is high, and otherwise keeps the last written value.
- R8: `busy_o` is high from the cycle after an accepted request until `done_o` rises. It is low in the `done_o` cycle, and `wr_o` never rises while `busy_o` is low.
- R9: Enter and exit requests that arrive while `busy_o` is high are ignored. They do not change the written sequence or its timing.
- R10: If enter and exit are both high in an idle cycle, the enter request is taken.
- R11: An exit request whose stored code is below 2 writes nothing and only settles. Since reset the stored code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enter_i | input | 1 | Request to ramp down to the programming floor |
| exit_i | input | 1 | Request to ramp back up to the stored code |
| cur_code_i | input | CODE_W | Present target code, sampled on an accepted enter |
| code_o | output | CODE_W | Target code sent to the regulator |
| wr_o | output | 1 | One-cycle strobe marking a new `code_o` |
| busy_o | output | 1 | A ramp or settle is in progress |
| done_o | output | 1 | One-cycle pulse when the settle ends |

## Verification
Take the clock edge that samples a request as offset 0. Write k of a ramp (counting from 0) is then visible at offset k*STEP, and `done_o` at offset n*STEP + SETTLE. The bench drives its requests at the falling edge and samples every output at the falling edge that follows each rising edge. It stamps each sample with a count of rising edges, so it can compare the cycle offset of each observed write and of the done pulse with these formulas. The bench tracks the stored code with its own model, so the expected exit sequence does not depend on the design's internal state.

// File: rtl/vramp_pkg.sv
package vramp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DWELL,
    ST_SETTLE
  } vr_state_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_START_DN,  // store input, write input-1
    CMD_STORE,     // store input, no write
    CMD_START_UP,  // write floor
    CMD_DEC,
    CMD_INC
  } vr_cmd_e;

endpackage

// File: rtl/vramp_timer.sv
module vramp_timer #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  output logic             zero_o
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/vramp_code.sv
module vramp_code
  import vramp_pkg::*;
#(
  parameter int unsigned CODE_W = 5,
  parameter int unsigned FLOOR  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  vr_cmd_e           cmd_i,
  input  logic [CODE_W-1:0] cur_i,
  output logic [CODE_W-1:0] code_o,
  output logic              wr_o,
  output logic              cur_above_o,
  output logic              code_above_o,
  output logic              code_below_o,
  output logic              saved_ok_o
);

  localparam logic [CODE_W-1:0] FLOOR_C = CODE_W'(FLOOR);

  logic [CODE_W-1:0] code_q, saved_q;
  logic              wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      saved_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      unique case (cmd_i)
        CMD_START_DN: begin
          saved_q <= cur_i;
          code_q  <= cur_i - 1'b1;
          wr_q    <= 1'b1;
        end
        CMD_STORE:    saved_q <= cur_i;
        CMD_START_UP: begin
          code_q <= FLOOR_C;
          wr_q   <= 1'b1;
        end
        CMD_DEC: begin
          code_q <= code_q - 1'b1;
          wr_q   <= 1'b1;
        end
        CMD_INC: begin
          code_q <= code_q + 1'b1;
          wr_q   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign code_o       = code_q;
  assign wr_o         = wr_q;
  assign cur_above_o  = (cur_i > FLOOR_C);
  assign code_above_o = (code_q > FLOOR_C);
  assign code_below_o = (code_q < saved_q);
  assign saved_ok_o   = (saved_q >= FLOOR_C);

endmodule

// File: rtl/vramp_fsm.sv
module vramp_fsm
  import vramp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    enter_i,
  input  logic    exit_i,
  input  logic    cur_above_i,
  input  logic    code_above_i,
  input  logic    code_below_i,
  input  logic    saved_ok_i,
  input  logic    tmr_zero_i,
  output vr_cmd_e cmd_o,
  output logic    tmr_load_o,
  output logic    tmr_settle_o,
  output logic    busy_o,
  output logic    done_o
);

  vr_state_e state_q, state_d;
  logic      down_q, down_d;
  logic      done_q, done_d;

  always_comb begin
    state_d      = state_q;
    down_d       = down_q;
    done_d       = 1'b0;
    cmd_o        = CMD_NONE;
    tmr_load_o   = 1'b0;
    tmr_settle_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (enter_i) begin
          down_d     = 1'b1;
          tmr_load_o = 1'b1;
          if (cur_above_i) begin
            cmd_o   = CMD_START_DN;
            state_d = ST_DWELL;
          end else begin
            cmd_o        = CMD_STORE;
            tmr_settle_o = 1'b1;
            state_d      = ST_SETTLE;
          end
        end else if (exit_i) begin
          down_d     = 1'b0;
          tmr_load_o = 1'b1;
          if (saved_ok_i) begin
            cmd_o   = CMD_START_UP;
            state_d = ST_DWELL;
          end else begin
            tmr_settle_o = 1'b1;
            state_d      = ST_SETTLE;
          end
        end
      end
      ST_DWELL: begin
        if (tmr_zero_i) begin
          tmr_load_o = 1'b1;
          if (down_q && code_above_i)       cmd_o = CMD_DEC;
          else if (!down_q && code_below_i) cmd_o = CMD_INC;
          else begin
            tmr_settle_o = 1'b1;
            state_d      = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        if (tmr_zero_i) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      down_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      down_q  <= down_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/vramp_seq.sv
module vramp_seq
  import vramp_pkg::*;
#(
  parameter int unsigned CODE_W     = 5,
  parameter int unsigned FLOOR      = 2,
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned STEP_US    = 500,
  parameter int unsigned SETTLE_US  = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enter_i,
  input  logic              exit_i,
  input  logic [CODE_W-1:0] cur_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              wr_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int unsigned STEP_CYC   = CYC_PER_US * STEP_US;
  localparam int unsigned SETTLE_CYC = CYC_PER_US * SETTLE_US;
  localparam int unsigned MAX_CYC    = (STEP_CYC > SETTLE_CYC) ? STEP_CYC : SETTLE_CYC;
  localparam int unsigned TMR_W      = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] STEP_LD   = TMR_W'(STEP_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);

  // dwell of one cycle would merge strobes
  if (STEP_CYC < 2)   $error("STEP dwell must be at least 2 cycles");
  if (SETTLE_CYC < 1) $error("settle must be at least 1 cycle");

  vr_cmd_e cmd;
  logic    tmr_load, tmr_settle, tmr_zero;
  logic    cur_above, code_above, code_below, saved_ok;

  vramp_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enter_i      (enter_i),
    .exit_i       (exit_i),
    .cur_above_i  (cur_above),
    .code_above_i (code_above),
    .code_below_i (code_below),
    .saved_ok_i   (saved_ok),
    .tmr_zero_i   (tmr_zero),
    .cmd_o        (cmd),
    .tmr_load_o   (tmr_load),
    .tmr_settle_o (tmr_settle),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  vramp_code #(
    .CODE_W (CODE_W),
    .FLOOR  (FLOOR)
  ) i_code (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .cur_i        (cur_code_i),
    .code_o       (code_o),
    .wr_o         (wr_o),
    .cur_above_o  (cur_above),
    .code_above_o (code_above),
    .code_below_o (code_below),
    .saved_ok_o   (saved_ok)
  );

  vramp_timer #(
    .TMR_W (TMR_W)
  ) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_settle ? SETTLE_LD : STEP_LD),
    .zero_o (tmr_zero)
  );

endmodule

// File: rtl/vramp_chk.sv
module vramp_chk #(
  parameter int unsigned CODE_W = 5,
  parameter int unsigned FLOOR  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enter_i,
  input logic              exit_i,
  input logic [CODE_W-1:0] code_o,
  input logic              wr_o,
  input logic              busy_o,
  input logic              done_o
);

  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o); // R7

  AST_CODE_WITH_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> wr_o); // R7

  AST_CODE_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (code_o >= CODE_W'(FLOOR))); // R2

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R8

  AST_WR_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> busy_o); // R8

  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (enter_i || exit_i)) |=> busy_o); // R8

endmodule

bind vramp_seq vramp_chk #(.CODE_W(CODE_W), .FLOOR(FLOOR)) i_chk (.*);

// File: tb/test_vramp_seq.sv
module test_vramp_seq;

  localparam int CW     = 5;
  localparam int CPU    = 2;
  localparam int SUS    = 3;
  localparam int TUS    = 5;
  localparam int STEP   = CPU * SUS;
  localparam int SETTLE = CPU * TUS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enter = 1'b0;
  logic          exit_r = 1'b0;
  logic [CW-1:0] cur = '0;
  logic [CW-1:0] code;
  logic          wr, busy, done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int saved_m = 0;
  int last_code = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vramp_seq #(
    .CODE_W (CW), .FLOOR (2), .CYC_PER_US (CPU), .STEP_US (SUS), .SETTLE_US (TUS)
  ) i_vramp_seq (
    .clk_i (clk), .rst_ni (rst_n), .enter_i (enter), .exit_i (exit_r),
    .cur_code_i (cur), .code_o (code), .wr_o (wr), .busy_o (busy), .done_o (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive one request and compare the ramp against the bench model
  task automatic run_op(input bit en, input bit ex, input int c, input bit disturb,
                        input string req);
    int exp_c[40];
    int n = 0;
    int got_c[40];
    int got_o[40];
    int g = 0;
    int c0;
    int done_off = -1;
    bit busy_ok = 1'b1;
    bit seq_ok = 1'b1;
    if (en) begin
      saved_m = c;
      for (int v = c - 1; v >= 2; v--) begin exp_c[n] = v; n++; end
    end else if (ex) begin
      for (int v = 2; v <= saved_m; v++) begin exp_c[n] = v; n++; end
    end
    @(negedge clk);
    enter  = en;
    exit_r = ex;
    cur    = CW'(c);
    c0 = cyc + 1;
    for (int k = 0; k < 40 * STEP + SETTLE + 20; k++) begin
      @(negedge clk);
      enter  = 1'b0;
      exit_r = 1'b0;
      if (disturb && k == 3) begin
        enter  = 1'b1;   // R9: must be ignored
        exit_r = 1'b1;
        cur    = CW'(c ^ 5'h1f);
      end
      if (wr && g < 40) begin
        got_c[g] = int'(code);
        got_o[g] = cyc - c0;
        g++;
      end
      if (done) begin
        done_off = cyc - c0;
        if (busy) busy_ok = 1'b0;
        break;
      end
      if (!busy) busy_ok = 1'b0;
    end
    chk(g == n, {req, " write count"}, g, n);
    for (int i = 0; i < n && i < g; i++)
      if (got_c[i] != exp_c[i] || got_o[i] != i * STEP) seq_ok = 1'b0;
    chk(seq_ok, {req, " R5 code order and spacing"}, (g > 0) ? got_c[0] : -1,
        (n > 0) ? exp_c[0] : -1);
    chk(done_off == n * STEP + SETTLE, {req, " R6 done offset"}, done_off, n * STEP + SETTLE);
    chk(busy_ok, {req, " R8 busy window"}, int'(busy), 0);
    if (n > 0) last_code = exp_c[n-1];
    @(negedge clk);
    chk(int'(code) == last_code && !wr && !done, {req, " R7 hold after done"},
        int'(code), last_code);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(code == '0 && !wr && !busy && !done, "R1 reset state", int'(code), 0);

    run_op(0, 1, 0, 0, "R11 exit before any enter");
    run_op(1, 0, 31, 0, "R2 enter from 31");
    run_op(0, 1, 0, 0, "R4 exit to 31");
    run_op(1, 0, 2, 0, "R3 enter at floor");
    run_op(1, 0, 0, 0, "R3 enter below floor");
    run_op(0, 1, 0, 0, "R11 exit with stored 0");
    run_op(1, 0, 3, 0, "R2 enter from 3");
    run_op(0, 1, 0, 0, "R4 exit to 3");
    run_op(1, 1, 9, 0, "R10 enter beats exit");
    run_op(0, 1, 0, 1, "R9 exit with requests while busy");
    run_op(1, 0, 12, 1, "R9 enter with requests while busy");

    seed = $urandom(32'h5eed);
    for (int i = 0; i < 30; i++) begin
      int kind = int'($urandom % 3);
      run_op(kind != 1, kind != 0, int'($urandom % 32), bit'($urandom % 2), "R2 R4 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule